// File: doc/BRIEF.md
# Glitch-Free Clock Group Stop Controller

This block sits between a clock generator's dividers and its output drivers. It gates three groups of generated clocks: a processor group, a memory group and a bus group. Each group has its own active-low stop request. A shared active-low power-down input overrides all three groups. The stop and power-down inputs are asynchronous, so each group captures them through a synchronizer clocked by its own source clock.

Each group's gate enable is held in a register that updates on the falling edge of the source clock. The output is the source clock ANDed with that enable. A gated output therefore parks low, and when it restarts it always begins with a complete high phase.

The processor and bus groups must stay enabled for a minimum number of their own cycles after a restart. The memory group lets one more complete cycle pass before it parks. Every group also has one free-running output. Stop requests do not affect it, but power-down does.

Top module: `clkstop_ctrl`

## Requirements
- R1: While `rst_n` is low, every output is low. After reset is released, with no stop and no power-down pending, each output's first high pulse begins at the second rising edge of its source clock, and that pulse is a full high phase.
- R2: In the processor and bus groups, a low level on the stop input that is held over rising edges k1 and k2 of the source clock gives a final gated high pulse at k2. From k3 on, the gated outputs stay low. This assumes the minimum enable time has already passed.
- R3: In the memory group, the same stop timing adds one extra complete cycle. The last gated pulse is at k3, and the outputs are low from k4 on. A release also reaches the memory outputs one cycle later than the processor and bus groups (first pulse at k4).
- R4: When a stop input returns high and is sampled at rising edge k1, the processor and bus gated outputs give their first full high pulse at k3.
- R5: After a processor-group restart, at least `CPU_MIN_ON` (default 100) gated high pulses are delivered before a stop can park the group. A stop that arrives earlier takes effect at the falling edge that ends pulse `CPU_MIN_ON`.
- R6: After a bus-group restart, at least `BUS_MIN_ON` (default 10) gated high pulses are delivered before a stop can park that group.
- R7: A stop request on one group leaves the other groups' outputs unchanged.
- R8: Each group's free-running output keeps toggling with its source clock while that group's stop input is low.
- R9: When `pwrdn_n` is low and has been sampled by two rising edges of a group's source clock, every output of that group, free-running included, is low from the next falling edge onward. Power-down does not wait for the minimum enable time.
- R10: After `pwrdn_n` returns high, the free-running outputs resume with full pulses. The gated outputs resume according to their stop inputs, with a fresh minimum-enable window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cpu_clk | input | 1 | Processor-group source clock |
| mem_clk | input | 1 | Memory-group source clock |
| bus_clk | input | 1 | Bus-group source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_stop_n | input | 1 | Asynchronous active-low stop for the processor group |
| mem_stop_n | input | 1 | Asynchronous active-low stop for the memory group |
| bus_stop_n | input | 1 | Asynchronous active-low stop for the bus group |
| pwrdn_n | input | 1 | Asynchronous active-low power-down for all groups |
| cpu_gclk | output | N_CPU | Gated processor clocks |
| cpu_fclk | output | 1 | Free-running processor clock |
| mem_gclk | output | N_MEM | Gated memory clocks |
| mem_fclk | output | 1 | Free-running memory clock |
| bus_gclk | output | N_BUS | Gated bus clocks |
| bus_fclk | output | 1 | Free-running bus clock |

## Verification
On every falling edge, the assertions check three things: each enable holds steady through the high phase, no processor or bus gate closes before its minimum pulse count, and an enable or free-run enable falls only when a matching stop or power-down was present. The exact latencies need the bench's scenarios. These are the two-cycle park and restart, the extra memory cycle, a stop that arrives inside the minimum-enable window, and power-down striking a freshly restarted group. The bench compares every output against its reference model on each edge of all three clocks.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;
   typedef struct packed {
      logic en;    // gated outputs enabled
      logic fen;   // free-running output enabled
   } gate_ctl_t;
endpackage

// File: rtl/clkstop_sync.sv
module clkstop_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '1;
      else        sh <= STAGES'({sh, d});
   end

   assign q = sh[STAGES-1];
endmodule

// File: rtl/clkstop_gate.sv
module clkstop_gate
   import clkstop_pkg::*;
#(
   parameter int SYNC_STAGES  = 2,
   parameter int EXTRA_STAGES = 0,
   parameter int MIN_ON       = 1
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      stop_n,
   input  logic      pwrdn_n,
   output gate_ctl_t ctl
);
   localparam int CNT_W = (MIN_ON > 1) ? $clog2(MIN_ON) : 1;
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(MIN_ON - 1);

   if (MIN_ON < 1) begin : g_bad_min
      $error("clkstop_gate: MIN_ON must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("clkstop_gate: SYNC_STAGES must be at least 2");
   end

   logic run_s, run_q, pd_ok;
   logic en_q, fen_q;
   logic [CNT_W-1:0] cnt_q;

   clkstop_sync #(.STAGES(SYNC_STAGES)) u_stop_sync (
      .clk(clk), .rst_n(rst_n), .d(stop_n), .q(run_s));
   clkstop_sync #(.STAGES(SYNC_STAGES)) u_pd_sync (
      .clk(clk), .rst_n(rst_n), .d(pwrdn_n), .q(pd_ok));

   // memory-style groups let one more full cycle pass before parking
   if (EXTRA_STAGES == 0) begin : g_direct
      assign run_q = run_s;
   end else begin : g_extra
      clkstop_sync #(.STAGES(EXTRA_STAGES)) u_hold (
         .clk(clk), .rst_n(rst_n), .d(run_s), .q(run_q));
   end

   // enable only moves on the falling edge, i.e. while the clock is low
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= 1'b0;
         fen_q <= 1'b0;
         cnt_q <= '0;
      end else if (!pd_ok) begin
         en_q  <= 1'b0;
         fen_q <= 1'b0;
      end else begin
         fen_q <= 1'b1;
         if (!en_q) begin
            if (run_q) begin
               en_q  <= 1'b1;
               cnt_q <= '0;
            end
         end else if (!run_q && cnt_q == CNT_LAST) begin
            en_q <= 1'b0;
         end else if (cnt_q != CNT_LAST) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign ctl.en  = en_q;
   assign ctl.fen = fen_q;
endmodule

// File: rtl/clkstop_drive.sv
module clkstop_drive #(
   parameter int N = 1
) (
   input  logic         clk,
   input  logic         en,
   input  logic         fen,
   output logic [N-1:0] gclk,
   output logic         fclk
);
   for (genvar i = 0; i < N; i++) begin : g_out
      assign gclk[i] = clk & en;
   end
   assign fclk = clk & fen;
endmodule

// File: rtl/clkstop_ctrl.sv
module clkstop_ctrl
   import clkstop_pkg::*;
#(
   parameter int N_CPU       = 2,
   parameter int N_MEM       = 8,
   parameter int N_BUS       = 6,
   parameter int SYNC_STAGES = 2,
   parameter int CPU_MIN_ON  = 100,
   parameter int BUS_MIN_ON  = 10,
   parameter int MEM_MIN_ON  = 1,
   parameter int MEM_EXTRA   = 1
) (
   input  logic             cpu_clk,
   input  logic             mem_clk,
   input  logic             bus_clk,
   input  logic             rst_n,
   input  logic             cpu_stop_n,
   input  logic             mem_stop_n,
   input  logic             bus_stop_n,
   input  logic             pwrdn_n,
   output logic [N_CPU-1:0] cpu_gclk,
   output logic             cpu_fclk,
   output logic [N_MEM-1:0] mem_gclk,
   output logic             mem_fclk,
   output logic [N_BUS-1:0] bus_gclk,
   output logic             bus_fclk
);
   if (N_CPU < 1 || N_MEM < 1 || N_BUS < 1) begin : g_bad_width
      $error("clkstop_ctrl: every group needs at least one gated output");
   end
   if (SYNC_STAGES > 3) begin : g_bad_sync
      $error("clkstop_ctrl: SYNC_STAGES above 3 is not supported");
   end

   gate_ctl_t cpu_ctl, mem_ctl, bus_ctl;
   logic cpu_en, cpu_fen, mem_en, mem_fen, bus_en, bus_fen;

   clkstop_gate #(.SYNC_STAGES(SYNC_STAGES), .EXTRA_STAGES(0), .MIN_ON(CPU_MIN_ON)) u_cpu_gate (
      .clk(cpu_clk), .rst_n(rst_n), .stop_n(cpu_stop_n), .pwrdn_n(pwrdn_n), .ctl(cpu_ctl));
   clkstop_gate #(.SYNC_STAGES(SYNC_STAGES), .EXTRA_STAGES(MEM_EXTRA), .MIN_ON(MEM_MIN_ON)) u_mem_gate (
      .clk(mem_clk), .rst_n(rst_n), .stop_n(mem_stop_n), .pwrdn_n(pwrdn_n), .ctl(mem_ctl));
   clkstop_gate #(.SYNC_STAGES(SYNC_STAGES), .EXTRA_STAGES(0), .MIN_ON(BUS_MIN_ON)) u_bus_gate (
      .clk(bus_clk), .rst_n(rst_n), .stop_n(bus_stop_n), .pwrdn_n(pwrdn_n), .ctl(bus_ctl));

   assign cpu_en  = cpu_ctl.en;
   assign cpu_fen = cpu_ctl.fen;
   assign mem_en  = mem_ctl.en;
   assign mem_fen = mem_ctl.fen;
   assign bus_en  = bus_ctl.en;
   assign bus_fen = bus_ctl.fen;

   clkstop_drive #(.N(N_CPU)) u_cpu_drv (
      .clk(cpu_clk), .en(cpu_en), .fen(cpu_fen), .gclk(cpu_gclk), .fclk(cpu_fclk));
   clkstop_drive #(.N(N_MEM)) u_mem_drv (
      .clk(mem_clk), .en(mem_en), .fen(mem_fen), .gclk(mem_gclk), .fclk(mem_fclk));
   clkstop_drive #(.N(N_BUS)) u_bus_drv (
      .clk(bus_clk), .en(bus_en), .fen(bus_fen), .gclk(bus_gclk), .fclk(bus_fclk));
endmodule

// File: rtl/clkstop_ctrl_chk.sv
module clkstop_ctrl_chk #(
   parameter int CPU_MIN_ON = 100,
   parameter int BUS_MIN_ON = 10
) (
   input logic cpu_clk,
   input logic mem_clk,
   input logic bus_clk,
   input logic rst_n,
   input logic cpu_stop_n,
   input logic mem_stop_n,
   input logic bus_stop_n,
   input logic pwrdn_n,
   input logic cpu_en,
   input logic cpu_fen,
   input logic mem_en,
   input logic mem_fen,
   input logic bus_en,
   input logic bus_fen
);
   logic cpu_pos_en, mem_pos_en, bus_pos_en;
   logic [15:0] cpu_run, bus_run;
   logic [2:0] cpu_warm;

   always_ff @(posedge cpu_clk or negedge rst_n)
      if (!rst_n) cpu_pos_en <= 1'b0; else cpu_pos_en <= cpu_en;
   always_ff @(posedge mem_clk or negedge rst_n)
      if (!rst_n) mem_pos_en <= 1'b0; else mem_pos_en <= mem_en;
   always_ff @(posedge bus_clk or negedge rst_n)
      if (!rst_n) bus_pos_en <= 1'b0; else bus_pos_en <= bus_en;

   // pulses delivered in the current enabled run
   always_ff @(negedge cpu_clk or negedge rst_n) begin
      if (!rst_n) begin
         cpu_run  <= '0;
         cpu_warm <= '0;
      end else begin
         cpu_run  <= !cpu_en ? '0 : (cpu_run == 16'hFFFF ? cpu_run : cpu_run + 1'b1);
         cpu_warm <= (cpu_warm == 3'd7) ? cpu_warm : cpu_warm + 1'b1;
      end
   end
   always_ff @(negedge bus_clk or negedge rst_n) begin
      if (!rst_n) bus_run <= '0;
      else        bus_run <= !bus_en ? '0 : (bus_run == 16'hFFFF ? bus_run : bus_run + 1'b1);
   end

   // R1: enables hold steady through each high phase
   assert_cpu_full_pulse_R1: assert property (@(negedge cpu_clk) disable iff (!rst_n)
      cpu_en == cpu_pos_en);
   assert_mem_full_pulse_R1: assert property (@(negedge mem_clk) disable iff (!rst_n)
      mem_en == mem_pos_en);
   assert_bus_full_pulse_R1: assert property (@(negedge bus_clk) disable iff (!rst_n)
      bus_en == bus_pos_en);

   assert_cpu_min_on_R5: assert property (@(negedge cpu_clk) disable iff (!rst_n)
      ($fell(cpu_en) && cpu_fen) |-> (cpu_run >= 16'(CPU_MIN_ON)));
   assert_bus_min_on_R6: assert property (@(negedge bus_clk) disable iff (!rst_n)
      ($fell(bus_en) && bus_fen) |-> (bus_run >= 16'(BUS_MIN_ON)));

   assert_cpu_stop_cause_R2: assert property (@(negedge cpu_clk) disable iff (!rst_n)
      $fell(cpu_en) |-> $past(!cpu_stop_n || !pwrdn_n));
   assert_bus_stop_cause_R2: assert property (@(negedge bus_clk) disable iff (!rst_n)
      $fell(bus_en) |-> $past(!bus_stop_n || !pwrdn_n));
   assert_mem_isolated_R7: assert property (@(negedge mem_clk) disable iff (!rst_n)
      $fell(mem_en) |-> $past(!mem_stop_n || !pwrdn_n));

   assert_cpu_free_runs_R8: assert property (@(negedge cpu_clk) disable iff (!rst_n)
      $fell(cpu_fen) |-> $past(!pwrdn_n));
   assert_mem_free_runs_R8: assert property (@(negedge mem_clk) disable iff (!rst_n)
      $fell(mem_fen) |-> $past(!pwrdn_n));
   assert_bus_free_runs_R8: assert property (@(negedge bus_clk) disable iff (!rst_n)
      $fell(bus_fen) |-> $past(!pwrdn_n));

   assert_pwrdn_parks_R9: assert property (@(negedge cpu_clk) disable iff (!rst_n)
      (cpu_warm >= 3'd5 && !pwrdn_n && $past(!pwrdn_n) && $past(!pwrdn_n, 2)
       && $past(!pwrdn_n, 3) && $past(!pwrdn_n, 4)) |-> (!cpu_en && !cpu_fen));
endmodule

bind clkstop_ctrl clkstop_ctrl_chk #(.CPU_MIN_ON(CPU_MIN_ON), .BUS_MIN_ON(BUS_MIN_ON)) u_chk (
   .cpu_clk(cpu_clk), .mem_clk(mem_clk), .bus_clk(bus_clk), .rst_n(rst_n),
   .cpu_stop_n(cpu_stop_n), .mem_stop_n(mem_stop_n), .bus_stop_n(bus_stop_n),
   .pwrdn_n(pwrdn_n), .cpu_en(cpu_en), .cpu_fen(cpu_fen), .mem_en(mem_en),
   .mem_fen(mem_fen), .bus_en(bus_en), .bus_fen(bus_fen));

// File: tb/sim_clkstop_ctrl.sv
`timescale 1ns/100ps

module sim_clkstop_ref #(
   parameter int MIN_ON = 1,
   parameter int LAT    = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic stop_n,
   input  logic pwrdn_n,
   output logic exp_en,
   output logic exp_fen
);
   bit stop_q[$];
   bit pd_q[$];
   int pulses;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stop_q.delete();
         pd_q.delete();
         for (int i = 0; i < LAT; i++) stop_q.push_back(1'b1);
         for (int i = 0; i < 2; i++) pd_q.push_back(1'b1);
      end else begin
         stop_q.push_back(stop_n);
         void'(stop_q.pop_front());
         pd_q.push_back(pwrdn_n);
         void'(pd_q.pop_front());
      end
   end

   always @(negedge clk or negedge rst_n) begin
      if (!rst_n) begin
         exp_en = 1'b0; exp_fen = 1'b0; pulses = 0;
      end else if (!pd_q[0]) begin
         exp_en = 1'b0; exp_fen = 1'b0;
      end else begin
         exp_fen = 1'b1;
         if (!exp_en) begin
            if (stop_q[0]) begin exp_en = 1'b1; pulses = 0; end
         end else begin
            pulses++;
            if (!stop_q[0] && pulses >= MIN_ON) exp_en = 1'b0;
         end
      end
   end
endmodule

module sim_clkstop_ctrl;
   localparam int N_CPU = 2, N_MEM = 8, N_BUS = 6;

   logic cpu_clk = 0, mem_clk = 0, bus_clk = 0;
   logic rst_n = 0, cpu_stop_n = 1, mem_stop_n = 1, bus_stop_n = 1, pwrdn_n = 1;
   logic [N_CPU-1:0] cpu_gclk;
   logic [N_MEM-1:0] mem_gclk;
   logic [N_BUS-1:0] bus_gclk;
   logic cpu_fclk, mem_fclk, bus_fclk;
   logic c_en, c_fen, m_en, m_fen, b_en, b_fen;

   int checks = 0, errors = 0;
   bit done = 0;
   string tag = "R1";

   always #2.5 cpu_clk = ~cpu_clk;   // 200 MHz
   always #3   mem_clk = ~mem_clk;
   always #5   bus_clk = ~bus_clk;

   clkstop_ctrl u0 (
      .cpu_clk(cpu_clk), .mem_clk(mem_clk), .bus_clk(bus_clk), .rst_n(rst_n),
      .cpu_stop_n(cpu_stop_n), .mem_stop_n(mem_stop_n), .bus_stop_n(bus_stop_n),
      .pwrdn_n(pwrdn_n), .cpu_gclk(cpu_gclk), .cpu_fclk(cpu_fclk),
      .mem_gclk(mem_gclk), .mem_fclk(mem_fclk), .bus_gclk(bus_gclk), .bus_fclk(bus_fclk));

   sim_clkstop_ref #(.MIN_ON(100), .LAT(2)) ref_cpu (
      .clk(cpu_clk), .rst_n(rst_n), .stop_n(cpu_stop_n), .pwrdn_n(pwrdn_n), .exp_en(c_en), .exp_fen(c_fen));
   sim_clkstop_ref #(.MIN_ON(1), .LAT(3)) ref_mem (
      .clk(mem_clk), .rst_n(rst_n), .stop_n(mem_stop_n), .pwrdn_n(pwrdn_n), .exp_en(m_en), .exp_fen(m_fen));
   sim_clkstop_ref #(.MIN_ON(10), .LAT(2)) ref_bus (
      .clk(bus_clk), .rst_n(rst_n), .stop_n(bus_stop_n), .pwrdn_n(pwrdn_n), .exp_en(b_en), .exp_fen(b_fen));

   task automatic check(string what, int got, int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s %s at %0t: got %0h expected %0h", tag, what, $time, got, exp);
      end
   endtask

   // high phase: gated outputs follow the model's enable
   always @(posedge cpu_clk) begin
      #1;
      check("cpu gated", int'(cpu_gclk), c_en ? (1 << N_CPU) - 1 : 0);
      check("cpu free", int'(cpu_fclk), int'(c_fen));
   end
   always @(posedge mem_clk) begin
      #1;
      check("mem gated", int'(mem_gclk), m_en ? (1 << N_MEM) - 1 : 0);
      check("mem free", int'(mem_fclk), int'(m_fen));
   end
   always @(posedge bus_clk) begin
      #1;
      check("bus gated", int'(bus_gclk), b_en ? (1 << N_BUS) - 1 : 0);
      check("bus free", int'(bus_fclk), int'(b_fen));
   end
   // low phase: everything parked low (R1)
   always @(negedge cpu_clk) begin
      #1; check("cpu low phase R1", int'({cpu_gclk, cpu_fclk}), 0);
   end
   always @(negedge mem_clk) begin
      #1; check("mem low phase R1", int'({mem_gclk, mem_fclk}), 0);
   end
   always @(negedge bus_clk) begin
      #1; check("bus low phase R1", int'({bus_gclk, bus_fclk}), 0);
   end

   task automatic cyc(int n);
      #(5.0 * n);
   endtask

   initial begin
      #20.3;
      rst_n = 1;                 // R1: start-up
      cyc(250);
      tag = "R2/R7/R8";          // cpu stop; other groups and free output run
      cpu_stop_n = 0; cyc(60);
      tag = "R4";
      cpu_stop_n = 1; cyc(30);
      tag = "R5";                // stop inside the minimum-enable window
      cpu_stop_n = 0; cyc(150);
      cpu_stop_n = 1; cyc(120);
      tag = "R6/R7";
      bus_stop_n = 0; cyc(40);
      bus_stop_n = 1; cyc(6);
      bus_stop_n = 0; cyc(60);
      bus_stop_n = 1; cyc(40);
      tag = "R3";
      mem_stop_n = 0; cyc(40);
      mem_stop_n = 1; cyc(40);
      tag = "R9";                // power-down right after a cpu restart
      cpu_stop_n = 0; cyc(20);
      cpu_stop_n = 1; cyc(20);
      pwrdn_n = 0; cyc(50);
      tag = "R10";
      pwrdn_n = 1; cyc(150);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #500000;
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog %s: got timeout expected completion", tag);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule